// File: doc/BRIEF.md
# Serial Port Register Block

This block is the software-facing register file of a simple serial port. A processor reaches it through a plain read/write port addressed by byte offset. It holds a mode register, a control register, a spare port register and five sticky status flags. A write to the transmit data offset hands the byte to the serialiser as a one-cycle valid pulse. Received bytes from the serialiser land in a 16-entry FIFO, which software drains through the receive data offset.

A parameter picks one of two variants. The plain variant keeps every bit written to mode and control and ignores writes to the status register. The FIFO variant masks the mode and control writes, lets software clear status flags by writing zeros, and drives a transmit interrupt line from a control bit. In both variants the two transmit flags are set again by a status read while transmit is enabled. An access to an offset that holds no register raises a one-cycle error pulse.

Offsets: mode 0x00, control 0x08, transmit data 0x0C, status 0x10, receive data 0x14, port 0x20. Status bits: 6 transmit-end, 5 transmit-data-empty, 4 break, 1 receive-FIFO-full, 0 data-ready; the other bits read 0. Control bit 5 is transmit enable and control bit 7 is transmit interrupt enable.

Top module: `uart_regs`

## Requirements
- R1: After reset, mode reads 0x00, control reads 0x20, status reads 0x60, txIrq is 0, txValid is 0 and rxReady is 1.
- R2: The FIFO variant stores a mode write ANDed with 0x7B. The plain variant stores all 8 bits.
- R3: The FIFO variant stores a control write ANDed with 0xFA, and the plain variant stores all 8 bits. In both, a control write with bit 5 at 0 sets transmit-end (status bit 6).
- R4: In the FIFO variant, txIrq equals control bit 7 as last written. In the plain variant, txIrq stays 0.
- R5: A write to offset 0x0C gives txValid high for exactly the next cycle with txByte equal to the written byte, and it clears transmit-data-empty (status bit 5).
- R6: In the FIFO variant, a status write clears each flag whose bit is written 0 (bits 6, 5, 4, 1, 0) and leaves the flags written 1 unchanged. In the plain variant, status writes have no effect.
- R7: A status read returns the flags as they were before the read. When control bit 5 is 1, transmit-end and transmit-data-empty are both 1 after the read.
- R8: Received bytes are read back in arrival order from a 16-entry FIFO through offset 0x14. rxReady is 0 while 16 bytes are held. A byte offered while the FIFO is full is dropped. Once the FIFO has been full, receive-FIFO-full (status bit 1) is set.
- R9: Data-ready (status bit 0) becomes 1 while the FIFO holds any byte and cannot be cleared until the FIFO is empty. A read of 0x14 on an empty FIFO returns 0x00 and leaves the FIFO unchanged.
- R10: An access to any offset other than 0x00, 0x08, 0x0C, 0x10, 0x14 or 0x20 reads 0x00, changes no register, and makes busErr high for the next cycle only. Supported accesses leave busErr low.
- R11: A pulse on rxBreak sets the break flag (status bit 4).
- R12: The port register at 0x20 reads back the last byte written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busEn | input | 1 | Access strobe, one per cycle |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Byte offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the cycle of the read |
| busErr | output | 1 | Unsupported-offset pulse, cycle after the access |
| txValid | output | 1 | Transmit byte strobe |
| txByte | output | 8 | Transmit byte |
| txIrq | output | 1 | Transmit interrupt |
| rxValid | input | 1 | Received byte strobe |
| rxByte | input | 8 | Received byte |
| rxReady | output | 1 | Receive FIFO has space |
| rxBreak | input | 1 | Break detected pulse |

## Verification
On every cycle, the embedded properties check the following: the transmit strobe and the flag clear that follow a data write, the flag re-set after a status read, the transmit-end set on a control write, interrupt tracking, the FIFO bounds, refusal of a byte when full, data-ready following occupancy, and the origin of the error pulse. The bench scenarios are needed to show the variant masks and the per-bit zero-clear mapping. They also show FIFO ordering across a full fill and drain, the dropped seventeenth byte, the empty read leaving the FIFO unchanged, and the fact that unsupported writes leave every register as it was.

// File: rtl/uart_regs_pkg.sv
`timescale 1ns/1ps
package uart_regs_pkg;
  localparam int OFS_MODE = 'h00;
  localparam int OFS_CTRL = 'h08;
  localparam int OFS_TXD  = 'h0C;
  localparam int OFS_STAT = 'h10;
  localparam int OFS_RXD  = 'h14;
  localparam int OFS_PORT = 'h20;

  localparam int ST_TEND = 6;
  localparam int ST_TDE  = 5;
  localparam int ST_BRK  = 4;
  localparam int ST_RDF  = 1;
  localparam int ST_DR   = 0;
  localparam int CTRL_TXEN  = 5;
  localparam int CTRL_TXIRQ = 7;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MODE, SEL_CTRL, SEL_TXD, SEL_STAT, SEL_RXD, SEL_PORT
  } rdSel_e;

  typedef struct packed {
    logic   wrMode;
    logic   wrCtrl;
    logic   wrTx;
    logic   wrStat;
    logic   wrPort;
    logic   rdStat;
    logic   rdRx;
    rdSel_e sel;
  } strobes_t;
endpackage

// File: rtl/uart_regs_ctrl.sv
`timescale 1ns/1ps
module uart_regs_ctrl
  import uart_regs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busEn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobes_t          strb,
  output logic              errPulse
);
  logic hit;
  rdSel_e sel;

  always_comb begin
    hit = 1'b1;
    sel = SEL_NONE;
    case (busAddr)
      ADDR_W'(OFS_MODE): sel = SEL_MODE;
      ADDR_W'(OFS_CTRL): sel = SEL_CTRL;
      ADDR_W'(OFS_TXD):  sel = SEL_TXD;
      ADDR_W'(OFS_STAT): sel = SEL_STAT;
      ADDR_W'(OFS_RXD):  sel = SEL_RXD;
      ADDR_W'(OFS_PORT): sel = SEL_PORT;
      default:           hit = 1'b0;
    endcase
  end

  always_comb begin
    strb = '0;
    if (busEn && hit) begin
      if (busWr) begin
        strb.wrMode = (sel == SEL_MODE);
        strb.wrCtrl = (sel == SEL_CTRL);
        strb.wrTx   = (sel == SEL_TXD);
        strb.wrStat = (sel == SEL_STAT);
        strb.wrPort = (sel == SEL_PORT);
      end else begin
        strb.rdStat = (sel == SEL_STAT);
        strb.rdRx   = (sel == SEL_RXD);
        strb.sel    = sel;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) errPulse <= 1'b0;
    else     errPulse <= busEn && !hit;
  end

  // R10: an error pulse only ever follows a bus access
  a_r10_err_source: assert property (@(posedge clk) disable iff (rst)
    errPulse |-> $past(busEn));
endmodule

// File: rtl/uart_regs_data.sv
`timescale 1ns/1ps
module uart_regs_data
  import uart_regs_pkg::*;
#(
  parameter bit FIFO_MODE = 1'b1,
  parameter int RX_DEPTH  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  strobes_t   strb,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       txValid,
  output logic [7:0] txByte,
  output logic       txIrq,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  output logic       rxReady,
  input  logic       rxBreak
);
  localparam int CNT_W = $clog2(RX_DEPTH + 1);
  localparam int PTR_W = $clog2(RX_DEPTH);
  localparam logic [7:0] MODE_MASK = FIFO_MODE ? 8'h7B : 8'hFF;
  localparam logic [7:0] CTRL_MASK = FIFO_MODE ? 8'hFA : 8'hFF;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(RX_DEPTH);

  logic [7:0] modeReg, ctrlReg, portReg, txdReg;
  logic tend, tde, brk, rdf, dr;
  logic nTend, nTde, nBrk, nRdf, nDr;
  logic [7:0] mem [RX_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic push, pop, full, empty;

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign push    = rxValid && !full;
  assign pop     = strb.rdRx && !empty;
  assign rxReady = !full;
  assign txByte  = txdReg;

  // plain registers
  always_ff @(posedge clk) begin
    if (rst) begin
      modeReg <= 8'h00;
      ctrlReg <= 8'h20;
      portReg <= 8'h00;
      txdReg  <= 8'h00;
      txValid <= 1'b0;
    end else begin
      if (strb.wrMode) modeReg <= wdata & MODE_MASK;
      if (strb.wrCtrl) ctrlReg <= wdata & CTRL_MASK;
      if (strb.wrPort) portReg <= wdata;
      if (strb.wrTx)   txdReg  <= wdata;
      txValid <= strb.wrTx;
    end
  end

  // sticky flags: sources that set win over a software clear
  always_comb begin
    nTend = tend; nTde = tde; nBrk = brk; nRdf = rdf; nDr = dr;
    if (FIFO_MODE && strb.wrStat) begin
      if (!wdata[ST_TEND]) nTend = 1'b0;
      if (!wdata[ST_TDE])  nTde  = 1'b0;
      if (!wdata[ST_BRK])  nBrk  = 1'b0;
      if (!wdata[ST_RDF])  nRdf  = 1'b0;
      if (!wdata[ST_DR])   nDr   = 1'b0;
    end
    if (strb.wrCtrl && !wdata[CTRL_TXEN]) nTend = 1'b1;
    if (strb.wrTx) nTde = 1'b0;
    if (strb.rdStat && ctrlReg[CTRL_TXEN]) begin
      nTde  = 1'b1;
      nTend = 1'b1;
    end
    if (rxBreak) nBrk = 1'b1;
    if (full)    nRdf = 1'b1;
    if (!empty)  nDr  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tend <= 1'b1; tde <= 1'b1; brk <= 1'b0; rdf <= 1'b0; dr <= 1'b0;
    end else begin
      tend <= nTend; tde <= nTde; brk <= nBrk; rdf <= nRdf; dr <= nDr;
    end
  end

  // receive FIFO
  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= rxByte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_W'(RX_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PTR_W'(RX_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // read mux
  always_comb begin
    case (strb.sel)
      SEL_MODE: rdata = modeReg;
      SEL_CTRL: rdata = ctrlReg;
      SEL_TXD:  rdata = txdReg;
      SEL_STAT: rdata = {1'b0, tend, tde, brk, 2'b00, rdf, dr};
      SEL_RXD:  rdata = empty ? 8'h00 : mem[rdPtr];
      SEL_PORT: rdata = portReg;
      default:  rdata = 8'h00;
    endcase
  end

  generate
    if (FIFO_MODE) begin : g_irq
      assign txIrq = ctrlReg[CTRL_TXIRQ];
      // R4: interrupt line follows the written enable bit
      a_r4_irq_follow: assert property (@(posedge clk) disable iff (rst)
        strb.wrCtrl |=> (txIrq == $past(wdata[CTRL_TXIRQ])));
    end else begin : g_noirq
      assign txIrq = 1'b0;
    end
  endgenerate

  // R5: data write gives a strobe and clears transmit-data-empty
  a_r5_tx_strobe: assert property (@(posedge clk) disable iff (rst)
    strb.wrTx |=> (txValid && !tde));
  // R7: status read with transmit enabled re-arms both transmit flags
  a_r7_read_rearm: assert property (@(posedge clk) disable iff (rst)
    (strb.rdStat && ctrlReg[CTRL_TXEN]) |=> (tde && tend));
  // R3: control write with transmit enable low sets transmit-end
  a_r3_txen_low: assert property (@(posedge clk) disable iff (rst)
    (strb.wrCtrl && !wdata[CTRL_TXEN]) |=> tend);
  // R8: occupancy never exceeds the depth
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);
  // R8: a byte refused while full does not change occupancy
  a_r8_drop_full: assert property (@(posedge clk) disable iff (rst)
    (rxValid && !rxReady && !strb.rdRx) |=> $stable(count));
  // R9: a nonempty FIFO forces data-ready
  a_r9_dr_set: assert property (@(posedge clk) disable iff (rst)
    !empty |=> dr);
endmodule

// File: rtl/uart_regs.sv
`timescale 1ns/1ps
module uart_regs
  import uart_regs_pkg::*;
#(
  parameter bit FIFO_MODE = 1'b1,
  parameter int RX_DEPTH  = 16,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busEn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              busErr,
  output logic              txValid,
  output logic [7:0]        txByte,
  output logic              txIrq,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  output logic              rxReady,
  input  logic              rxBreak
);
  strobes_t strb;

  uart_regs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .busEn(busEn), .busWr(busWr), .busAddr(busAddr),
    .strb(strb), .errPulse(busErr)
  );

  uart_regs_data #(.FIFO_MODE(FIFO_MODE), .RX_DEPTH(RX_DEPTH)) u_data (
    .clk(clk), .rst(rst), .strb(strb), .wdata(busWdata), .rdata(busRdata),
    .txValid(txValid), .txByte(txByte), .txIrq(txIrq),
    .rxValid(rxValid), .rxByte(rxByte), .rxReady(rxReady), .rxBreak(rxBreak)
  );
endmodule

// File: tb/uart_regs_test.sv
`timescale 1ns/1ps
module uart_regs_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busEn = 1'b0, busWr = 1'b0;
  logic [5:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic rxValid = 1'b0, rxBreak = 1'b0;
  logic [7:0] rxByte = '0;
  logic [7:0] rdF, rdP, txByteF, txByteP;
  logic errF, errP, txValidF, txValidP, irqF, irqP, readyF, readyP;
  int checks = 0, errors = 0;
  logic [7:0] rF, rP;

  always #10 clk = ~clk;

  uart_regs #(.FIFO_MODE(1'b1)) uut (
    .clk(clk), .rst(rst), .busEn(busEn), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rdF), .busErr(errF), .txValid(txValidF),
    .txByte(txByteF), .txIrq(irqF), .rxValid(rxValid), .rxByte(rxByte),
    .rxReady(readyF), .rxBreak(rxBreak));

  uart_regs #(.FIFO_MODE(1'b0)) uutPlain (
    .clk(clk), .rst(rst), .busEn(busEn), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rdP), .busErr(errP), .txValid(txValidP),
    .txByte(txByteP), .txIrq(irqP), .rxValid(rxValid), .rxByte(rxByte),
    .rxReady(readyP), .rxBreak(rxBreak));

  typedef struct packed {
    logic       wr;
    logic [5:0] addr;
    logic [7:0] wdata;
    logic [7:0] expF;
    logic [7:0] expP;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'h00, 8'h00, 8'h00, 8'h00, 4'd1},   // R1 mode reset
    '{1'b0, 6'h08, 8'h00, 8'h20, 8'h20, 4'd1},   // R1 control reset
    '{1'b0, 6'h10, 8'h00, 8'h60, 8'h60, 4'd1},   // R1 status reset
    '{1'b1, 6'h00, 8'hFF, 8'h00, 8'h00, 4'd2},
    '{1'b0, 6'h00, 8'h00, 8'h7B, 8'hFF, 4'd2},   // R2 mode mask
    '{1'b1, 6'h08, 8'hFF, 8'h00, 8'h00, 4'd3},
    '{1'b0, 6'h08, 8'h00, 8'hFA, 8'hFF, 4'd3},   // R3 control mask
    '{1'b1, 6'h20, 8'hA5, 8'h00, 8'h00, 4'd12},
    '{1'b0, 6'h20, 8'h00, 8'hA5, 8'hA5, 4'd12},  // R12 port readback
    '{1'b1, 6'h00, 8'h04, 8'h00, 8'h00, 4'd2},
    '{1'b0, 6'h00, 8'h00, 8'h00, 8'h04, 4'd2}    // R2 bit 2 masked
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [5:0] addr, input logic [7:0] data,
                     output logic [7:0] oF, output logic [7:0] oP);
    @(negedge clk);
    busEn = 1'b1; busWr = wr; busAddr = addr; busWdata = data;
    #2;
    oF = rdF; oP = rdP;
    @(negedge clk);
    busEn = 1'b0; busWr = 1'b0;
  endtask

  task automatic rxPush(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxByte = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 port state after reset
    chk({7'b0, irqF}, 8'h00, "R1 txIrq");
    chk({7'b0, txValidF}, 8'h00, "R1 txValid");
    chk({7'b0, readyF}, 8'h01, "R1 rxReady");

    for (int i = 0; i < NV; i++) begin
      acc(VECS[i].wr, VECS[i].addr, VECS[i].wdata, rF, rP);
      if (!VECS[i].wr) begin
        chk(rF, VECS[i].expF, $sformatf("R%0d vec %0d fifo", VECS[i].tag, i));
        chk(rP, VECS[i].expP, $sformatf("R%0d vec %0d plain", VECS[i].tag, i));
      end
      chk({7'b0, errF}, 8'h00, "R10 no error on supported offset");
    end

    // R4 interrupt follows control bit 7 (written 1 in the table)
    chk({7'b0, irqF}, 8'h01, "R4 irq set");
    chk({7'b0, irqP}, 8'h00, "R4 plain irq");
    acc(1'b1, 6'h08, 8'h20, rF, rP);
    chk({7'b0, irqF}, 8'h00, "R4 irq cleared");

    // R6 zero-clear, R7 read re-arm
    acc(1'b1, 6'h10, 8'h00, rF, rP);
    acc(1'b0, 6'h10, 8'h00, rF, rP);
    chk(rF, 8'h00, "R6 all cleared");
    chk(rP, 8'h60, "R6 plain ignores status write");
    acc(1'b0, 6'h10, 8'h00, rF, rP);
    chk(rF, 8'h60, "R7 read re-arms");

    // R5 transmit strobe
    acc(1'b1, 6'h0C, 8'h41, rF, rP);
    chk({7'b0, txValidF}, 8'h01, "R5 txValid");
    chk(txByteF, 8'h41, "R5 txByte");
    @(negedge clk);
    chk({7'b0, txValidF}, 8'h00, "R5 single pulse");
    acc(1'b0, 6'h10, 8'h00, rF, rP);
    chk(rF, 8'h40, "R5 tde cleared");

    // R6 per-bit clears with transmit disabled, R3 tend set
    acc(1'b1, 6'h08, 8'h00, rF, rP);
    acc(1'b1, 6'h10, 8'hBF, rF, rP);
    acc(1'b0, 6'h10, 8'h00, rF, rP);
    chk(rF, 8'h20, "R6 only tend cleared");
    acc(1'b1, 6'h10, 8'hDF, rF, rP);
    acc(1'b0, 6'h10, 8'h00, rF, rP);
    chk(rF, 8'h00, "R6 tde cleared");
    acc(1'b1, 6'h08, 8'h00, rF, rP);
    acc(1'b0, 6'h10, 8'h00, rF, rP);
    chk(rF, 8'h40, "R3 txen low sets tend");

    // R11 break
    @(negedge clk) rxBreak = 1'b1;
    @(negedge clk) rxBreak = 1'b0;
    acc(1'b0, 6'h10, 8'h00, rF, rP);
    chk(rF, 8'h50, "R11 break flag");
    acc(1'b1, 6'h10, 8'hEF, rF, rP);
    acc(1'b0, 6'h10, 8'h00, rF, rP);
    chk(rF, 8'h40, "R6 break cleared");

    // R9 empty read, R8 fill, drop and drain
    acc(1'b0, 6'h14, 8'h00, rF, rP);
    chk(rF, 8'h00, "R9 empty read");
    for (int i = 0; i < 16; i++) rxPush(8'h10 + 8'(i));
    chk({7'b0, readyF}, 8'h00, "R8 not ready when full");
    acc(1'b0, 6'h10, 8'h00, rF, rP);
    chk(rF, 8'h43, "R8 full and ready flags");
    rxPush(8'hEE);
    for (int i = 0; i < 16; i++) begin
      acc(1'b0, 6'h14, 8'h00, rF, rP);
      chk(rF, 8'h10 + 8'(i), "R8 order");
      if (i == 0) chk({7'b0, readyF}, 8'h01, "R8 ready after pop");
    end
    acc(1'b0, 6'h14, 8'h00, rF, rP);
    chk(rF, 8'h00, "R8 overflow byte dropped");
    acc(1'b0, 6'h10, 8'h00, rF, rP);
    chk(rF, 8'h43, "R8 flags sticky after drain");
    acc(1'b1, 6'h10, 8'hFC, rF, rP);
    acc(1'b0, 6'h10, 8'h00, rF, rP);
    chk(rF, 8'h40, "R6 rdf and dr cleared");
    rxPush(8'h77);
    acc(1'b0, 6'h14, 8'h00, rF, rP);
    chk(rF, 8'h77, "R9 empty read left FIFO intact");

    // R9 data-ready cannot be cleared while nonempty
    rxPush(8'h55);
    acc(1'b1, 6'h10, 8'hFE, rF, rP);
    acc(1'b0, 6'h10, 8'h00, rF, rP);
    chk(rF, 8'h41, "R9 dr held while nonempty");
    acc(1'b0, 6'h14, 8'h00, rF, rP);
    chk(rF, 8'h55, "R9 byte read");

    // R10 unsupported offsets
    acc(1'b0, 6'h04, 8'h00, rF, rP);
    chk(rF, 8'h00, "R10 reads zero");
    chk({7'b0, errF}, 8'h01, "R10 error pulse");
    @(negedge clk);
    chk({7'b0, errF}, 8'h00, "R10 pulse one cycle");
    acc(1'b1, 6'h3C, 8'hFF, rF, rP);
    chk({7'b0, errF}, 8'h01, "R10 write error pulse");
    acc(1'b1, 6'h2A, 8'hFF, rF, rP);
    acc(1'b0, 6'h00, 8'h00, rF, rP);
    chk(rF, 8'h00, "R10 mode untouched");
    acc(1'b0, 6'h08, 8'h00, rF, rP);
    chk(rF, 8'h00, "R10 control untouched");
    acc(1'b0, 6'h20, 8'h00, rF, rP);
    chk(rF, 8'hA5, "R10 port untouched");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule